// File: doc/BRIEF.md
# Two-Phase Steering Phase Detector with Slip Clamp and Dead Time

This block turns four divided clocks into the high-side and low-side gate drives of two interleaved buck sub-converters, A and B. The four clocks are a set clock and a reset clock, each in a base version and a complementary version. A rising edge on a set clock starts an on-time. A rising edge on a reset clock ends the on-time of whichever sub-converter the steering state currently points at. The steering state follows the most recent set edge, so each set/reset pair controls one sub-converter in turn.

Two slip flags keep the phase difference inside its range instead of letting it wrap. The upper flag ties each request to the level of its set clock, which gives the widest allowed on-time. The lower flag forces both requests off and ignores set edges. A dead-time stage, driven by a run-time count of clock cycles, lets a high-side drive rise only after both drives have been low for long enough. The low-side drives are the complements of the high-side drives.

All inputs are synchronous to `clk`. A rising edge on a divided clock reaches the high-side drive on the second clock edge after it is sampled, unless the dead time holds it back.

Top module: `pwm_steer_pd`

## Requirements
- R1: While `rst_n` is low, and right after reset, `hs_a` and `hs_b` are 0, `ls_a` and `ls_b` are 1, and the steering state selects sub-converter A.
- R2: A rising edge on `set_div` selects A and starts the A request. A rising edge on `set_div_c` selects B and starts the B request.
- R3: A rising edge on `rst_div` or `rst_div_c` ends the request of the sub-converter selected at that edge, whichever reset clock produced it.
- R4: While `slip_top` is 1 and `slip_bot` is 0, the A request equals the level of `set_div` and the B request equals the level of `set_div_c`. A falling set clock then ends its on-time.
- R5: While `slip_bot` is 1, both requests are 0 and set edges have no effect, even when `slip_top` is also 1. After `slip_bot` clears, both drives stay low until the next set edge.
- R6: A high-side drive rises only after both high-side drives have been low for at least `dead_cycles`+1 clock cycles. With `dead_cycles`=0, the incoming drive rises on the edge after the outgoing drive falls.
- R7: `hs_a` and `hs_b` are never 1 at the same time.
- R8: `ls_a` is the inverse of `hs_a`, and `ls_b` is the inverse of `hs_b`, at all times.
- R9: A set-clock rising edge that is sampled at clock edge E drives its high-side output to 1 at edge E+1, provided the dead time has already elapsed. A reset edge drives it to 0 with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_div | input | 1 | Divided set clock, base version |
| set_div_c | input | 1 | Divided set clock, complementary version |
| rst_div | input | 1 | Divided reset clock, base version |
| rst_div_c | input | 1 | Divided reset clock, complementary version |
| slip_top | input | 1 | Phase difference at the top of its range |
| slip_bot | input | 1 | Phase difference at the bottom of its range |
| dead_cycles | input | DEAD_W | Dead time in clock cycles |
| hs_a | output | 1 | High-side drive, sub-converter A |
| hs_b | output | 1 | High-side drive, sub-converter B |
| ls_a | output | 1 | Low-side drive, sub-converter A |
| ls_b | output | 1 | Low-side drive, sub-converter B |

## Verification
The dead-time property compares a count of cycles in which both drives were low against the current `dead_cycles` value, so it assumes that `dead_cycles` changes only while both drives are low and settled. The bench therefore reprograms it only between scenarios, after the drives are off. The properties also assume that the divided clocks are synchronous levels, and that each set clock and reset clock returns low before its next rise. The stimulus moves every input half a period away from the active edge and lowers each clock before raising it again. It raises both set clocks together only when a slip flag makes their edges irrelevant.

// File: rtl/pwm_steer_pkg.sv
// Shared types for the two-phase steering phase detector.
package pwm_steer_pkg;
    // Which sub-converter the current set/reset pair belongs to.
    typedef enum logic {
        SUB_B = 1'b0,
        SUB_A = 1'b1
    } sub_e;

    // Bit positions of the divided clocks in the packed edge vector.
    localparam int CLK_N      = 4;
    localparam int IX_SET     = 0;
    localparam int IX_SET_C   = 1;
    localparam int IX_RST     = 2;
    localparam int IX_RST_C   = 3;
endpackage

// File: rtl/edge_pulse.sv
// edge_pulse: one-cycle pulse on each rising edge of a bank of synchronous
// level inputs. Assumes the inputs are already synchronous to clk.
module edge_pulse #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Remember the previous level of this input.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[i] <= 1'b0;
            else        lvl_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/steer_core.sv
// steer_core: the steering latch and the per-sub-converter on-time requests.
// The latch follows the most recent set edge. A reset edge ends the
// request of the selected sub-converter. slip_bot blanks both requests and
// takes priority over slip_top, which ties each request to its set level.
module steer_core
    import pwm_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLK_N-1:0] rise,
    input  logic             set_lvl,
    input  logic             set_lvl_c,
    input  logic             slip_top,
    input  logic             slip_bot,
    output sub_e             steer,
    output logic             req_a,
    output logic             req_b
);
    logic any_rst;
    assign any_rst = rise[IX_RST] | rise[IX_RST_C];

    // Steering latch: the base set edge wins when both set edges coincide.
    always_ff @(posedge clk) begin
        if (!rst_n)               steer <= SUB_A;
        else if (rise[IX_SET])    steer <= SUB_A;
        else if (rise[IX_SET_C])  steer <= SUB_B;
    end

    // On-time requests, with slip clamping taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_a <= 1'b0;
            req_b <= 1'b0;
        end else if (slip_bot) begin
            req_a <= 1'b0;
            req_b <= 1'b0;
        end else if (slip_top) begin
            req_a <= set_lvl;
            req_b <= set_lvl_c;
        end else begin
            if (rise[IX_SET])                     req_a <= 1'b1;
            else if (any_rst && steer == SUB_A)   req_a <= 1'b0;
            if (rise[IX_SET_C])                   req_b <= 1'b1;
            else if (any_rst && steer == SUB_B)   req_b <= 1'b0;
        end
    end
endmodule

// File: rtl/dead_time.sv
// dead_time: turns the two requests into high-side drives that never
// overlap. A drive may rise only while the other is low and after both
// have been low for dead+1 cycles. A falling request drops its drive on
// the next edge. If both requests compete, the steering state picks one.
module dead_time
    import pwm_steer_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_a,
    input  logic              req_b,
    input  sub_e              steer,
    input  logic [DEAD_W-1:0] dead,
    output logic              hs_a,
    output logic              hs_b
);
    localparam logic [DEAD_W-1:0] GAP_MAX = '1;

    logic [DEAD_W-1:0] gap;
    logic              open_w;
    logic              nxt_a;
    logic              nxt_b;

    assign open_w = (gap >= dead);

    // Grant logic: keep a held drive, or admit a new one once the gap is open.
    always_comb begin
        nxt_a = req_a & (hs_a | (~hs_b & open_w & (~req_b | steer == SUB_A)));
        nxt_b = req_b & (hs_b | (~hs_a & open_w & (~req_a | steer == SUB_B)));
    end

    // Count the cycles both drives have been low, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap <= '0;
        else if (hs_a | hs_b)     gap <= '0;
        else if (gap != GAP_MAX)  gap <= gap + 1'b1;
    end

    // Register the drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_a <= 1'b0;
            hs_b <= 1'b0;
        end else begin
            hs_a <= nxt_a;
            hs_b <= nxt_b;
        end
    end
endmodule

// File: rtl/pwm_steer_pd.sv
// pwm_steer_pd: two-phase steering phase detector. Converts divided
// set/reset clocks into non-overlapping gate drives for two interleaved
// sub-converters, with slip clamping and a programmable dead time.
// Assumes all inputs are synchronous to clk.
module pwm_steer_pd
    import pwm_steer_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_div,
    input  logic              set_div_c,
    input  logic              rst_div,
    input  logic              rst_div_c,
    input  logic              slip_top,
    input  logic              slip_bot,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              hs_a,
    output logic              hs_b,
    output logic              ls_a,
    output logic              ls_b
);
    logic [CLK_N-1:0] lvl;
    logic [CLK_N-1:0] rise;
    sub_e             steer;
    logic             req_a;
    logic             req_b;

    always_comb begin
        lvl           = '0;
        lvl[IX_SET]   = set_div;
        lvl[IX_SET_C] = set_div_c;
        lvl[IX_RST]   = rst_div;
        lvl[IX_RST_C] = rst_div_c;
    end

    edge_pulse #(.W(CLK_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    steer_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .set_lvl   (set_div),
        .set_lvl_c (set_div_c),
        .slip_top  (slip_top),
        .slip_bot  (slip_bot),
        .steer     (steer),
        .req_a     (req_a),
        .req_b     (req_b)
    );

    dead_time #(.DEAD_W(DEAD_W)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .req_a (req_a),
        .req_b (req_b),
        .steer (steer),
        .dead  (dead_cycles),
        .hs_a  (hs_a),
        .hs_b  (hs_b)
    );

    assign ls_a = ~hs_a;
    assign ls_b = ~hs_b;
endmodule

// File: rtl/pwm_steer_pd_chk.sv
// pwm_steer_pd_chk: property checker bound to pwm_steer_pd. Assumes that
// dead_cycles changes only while both drives are low and settled.
module pwm_steer_pd_chk
    import pwm_steer_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_div,
    input logic              slip_top,
    input logic              slip_bot,
    input logic [DEAD_W-1:0] dead_cycles,
    input logic              hs_a,
    input logic              hs_b,
    input sub_e              steer
);
    logic [7:0] low_run;

    // Independent count of the cycles both drives have been low.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (hs_a | hs_b)    low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 1'b1;
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a && hs_b));

    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_a) || $rose(hs_b)) |-> (low_run > 8'(dead_cycles)));

    p_bot_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_bot && $past(slip_bot)) |=> (!hs_a && !hs_b));

    p_top_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_top && !slip_bot && !set_div && $past(slip_top && !slip_bot && !set_div))
        |=> !hs_a);

    p_steer_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_div) |=> (steer == SUB_A));
endmodule

bind pwm_steer_pd pwm_steer_pd_chk #(.DEAD_W(DEAD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_div     (set_div),
    .slip_top    (slip_top),
    .slip_bot    (slip_bot),
    .dead_cycles (dead_cycles),
    .hs_a        (hs_a),
    .hs_b        (hs_b),
    .steer       (steer)
);

// File: tb/sim_pwm_steer_pd.sv
// Scoreboard bench: tasks queue expected drive values stamped with a
// falling-edge count; the monitor compares them at that falling edge.
module sim_pwm_steer_pd;
    localparam int PERIOD = 10;
    localparam int DW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_div = 1'b0, set_div_c = 1'b0;
    logic          rst_div = 1'b0, rst_div_c = 1'b0;
    logic          slip_top = 1'b0, slip_bot = 1'b0;
    logic [DW-1:0] dead_cycles = 4'd2;
    logic          hs_a, hs_b, ls_a, ls_b;

    int checks = 0;
    int fails  = 0;
    int ncnt   = 0;

    typedef struct {
        int    cyc;
        logic  a;
        logic  b;
        string tag;
    } exp_t;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    pwm_steer_pd #(.DEAD_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .set_div(set_div), .set_div_c(set_div_c),
        .rst_div(rst_div), .rst_div_c(rst_div_c),
        .slip_top(slip_top), .slip_bot(slip_bot),
        .dead_cycles(dead_cycles),
        .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b)
    );

    // Monitor: count falling edges and compare the due expectations.
    always @(negedge clk) begin
        ncnt = ncnt + 1;
        while (q.size() > 0 && q[0].cyc <= ncnt) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hs_a !== e.a || hs_b !== e.b) begin
                fails++;
                $display("FAIL %s: hs_a/hs_b actual=%b%b expected=%b%b (cycle %0d)",
                         e.tag, hs_a, hs_b, e.a, e.b, ncnt);
            end else if (ls_a !== ~e.a || ls_b !== ~e.b) begin
                fails++;
                $display("FAIL R8: ls_a/ls_b actual=%b%b expected=%b%b (cycle %0d)",
                         ls_a, ls_b, ~e.a, ~e.b, ncnt);
            end
        end
    end

    // Queue an expectation 'ofs' falling edges after the current one.
    task automatic expect_at(input int ofs, input logic a, input logic b, input string tag);
        exp_t e;
        e.cyc = ncnt + ofs;
        e.a   = a;
        e.b   = b;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Move to just after the next falling edge, where inputs are driven.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL R9: watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(1, 1'b0, 1'b0, "R1 reset state");
        tick(10);

        // R2/R9: base set edge starts A two edges after sampling.
        set_div = 1'b1;
        expect_at(1, 1'b0, 1'b0, "R9 latency");
        expect_at(2, 1'b1, 1'b0, "R2 set A");
        tick(4);

        // R3/R6: reset ends A; the complementary set waits for the dead time.
        rst_div = 1'b1; set_div_c = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R3 reset A");
        expect_at(4, 1'b0, 1'b0, "R6 gap held");
        expect_at(5, 1'b0, 1'b1, "R6 B after gap");
        tick(6);
        set_div = 1'b0; rst_div = 1'b0;
        tick(2);

        // R3: steering is B, so the base reset clock ends B.
        rst_div = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R3 steered reset");
        tick(3);
        set_div_c = 1'b0; rst_div = 1'b0;
        tick(4);

        // R4: upper slip ties the requests to the set levels.
        slip_top = 1'b1; set_div = 1'b1;
        expect_at(2, 1'b1, 1'b0, "R4 follow A");
        tick(3);
        set_div = 1'b0; set_div_c = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R4 A drops");
        expect_at(5, 1'b0, 1'b1, "R4 follow B");
        tick(6);
        set_div_c = 1'b0;
        expect_at(2, 1'b0, 1'b0, "R4 level ends B");
        tick(4);
        slip_top = 1'b0;
        tick(2);

        // R5: lower slip blanks both drives and ignores set edges.
        set_div_c = 1'b1;
        expect_at(2, 1'b0, 1'b1, "R2 set B");
        tick(4);
        slip_bot = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R5 blank");
        tick(3);
        set_div = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R5 set ignored");
        expect_at(8, 1'b0, 1'b0, "R5 still low");
        tick(9);
        slip_bot = 1'b0;
        expect_at(3, 1'b0, 1'b0, "R5 low after clear");
        tick(4);
        set_div = 1'b0; set_div_c = 1'b0;
        tick(2);
        set_div = 1'b1;
        expect_at(2, 1'b1, 1'b0, "R5 resume on set");
        tick(4);

        // R5: lower slip has priority over upper slip.
        slip_top = 1'b1; slip_bot = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R5 priority");
        tick(3);
        slip_top = 1'b0; slip_bot = 1'b0;
        tick(2);
        set_div = 1'b0;
        tick(6);

        // R6: zero dead time hands over on the following edge.
        dead_cycles = 4'd0;
        set_div_c = 1'b1;
        expect_at(2, 1'b0, 1'b1, "R2 set B dead0");
        tick(4);
        rst_div_c = 1'b1; set_div = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R6 dead0 gap");
        expect_at(3, 1'b1, 1'b0, "R6 dead0 handover");
        tick(5);
        set_div = 1'b0; set_div_c = 1'b0; rst_div_c = 1'b0;
        tick(3);

        // R6: longer dead time of five cycles.
        dead_cycles = 4'd5;
        rst_div = 1'b1; set_div_c = 1'b1;
        expect_at(2, 1'b0, 1'b0, "R3 reset A dead5");
        expect_at(7, 1'b0, 1'b0, "R6 dead5 held");
        expect_at(8, 1'b0, 1'b1, "R6 dead5 B");
        tick(10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule